// File: doc/BRIEF.md
# ADC Parallel-Bus Control Interface

This block is the digital front end of a 12-bit, eight-channel sampling converter attached to a microprocessor parallel bus. It decodes three active-low strobes: select, read and write. On a write it captures a control word from the 12-bit data bus. The control word holds a channel address, a software-start flag, a standby flag and an output-coding flag. Each completed write starts a settling count. When that count expires with software start set and standby clear, the block issues a one-cycle hold/convert start to the converter.

The converter core is outside the block. It returns a raw 12-bit straight-binary result together with a one-cycle done pulse. On a bus read, the block places the last captured result on the bus. The result is coded as straight binary or as two's complement, chosen by the coding flag. Select and write are brought into the system clock through a synchroniser chain before edge detection. The read path is combinational from the strobes to the output enable. The bus is modelled as separate input, output and output-enable vectors.

Top module: `adc_bus_ctrl`

## Requirements
- R1: After reset the control word is all zero: channel 0, standby low, software start low, coding straight binary. In addition, hold_start and bus_oe are low.
- R2: bus_oe is high exactly while bus_cs_n and bus_rd_n are both low. While bus_oe is low, bus_dout is all zero.
- R3: A write is a rising edge of bus_wr_n seen while bus_cs_n was low. The control word takes the bus value that was present at the last low sample of the write strobe. The new value is visible from the third clock edge after the strobe rises (SYNC_STAGES+1 edges). The field positions are: coding flag on bit 11, standby on bit 10, software start on bit 9, and channel address on bits 8..6. Bits 5..0 are ignored.
- R4: A write-strobe pulse with bus_cs_n high leaves the control word unchanged.
- R5: A write with software start 1 and standby 0 produces hold_start. The pulse is asserted exactly SETTLE_CYCLES clock edges after the edge at which the control word updated.
- R6: A write with software start 0 produces no hold_start.
- R7: A further write that arrives before the settling count expires restarts the count from SETTLE_CYCLES. The earlier write yields no pulse.
- R8: standby_req equals the standby flag. While standby_req is high, no hold_start is produced.
- R9: conv_result is captured on each clock edge where conv_done is high. With the coding flag at 0, reads return the captured result unchanged.
- R10: With the coding flag at 1, reads return the captured result with bit 11 inverted (two's complement).
- R11: hold_start is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Active-low select strobe |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_din | input | 12 | Data bus value seen by the block |
| bus_dout | output | 12 | Read data driven onto the bus |
| bus_oe | output | 1 | Bus drive enable; the bus floats when low |
| conv_done | input | 1 | One-cycle pulse from the converter: result is valid |
| conv_result | input | 12 | Raw straight-binary conversion result |
| chan_sel | output | 3 | Selected input channel |
| standby_req | output | 1 | Power-down request to the converter |
| hold_start | output | 1 | One-cycle hold and conversion start |

## Verification
The bench aims at four corner cases.

- A second write lands inside the settling window. A design that fails to restart the count fires early, or fires twice.
- A write strobe toggles with select high. A design that ignores select overwrites the channel.
- Standby is set together with software start. A design that leaks through issues a start while powered down.
- A result with only the MSB set is read in both codings. This exposes an inverted or missing MSB flip.

A cycle-accurate model also catches any write capture that is off by one synchroniser stage, because the channel output would then change a cycle early or late.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
   localparam int unsigned BUS_W     = 12;
   localparam int unsigned ADDR_W    = 3;
   localparam int unsigned FMT_POS   = 11;
   localparam int unsigned STBY_POS  = 10;
   localparam int unsigned SWC_POS   = 9;
   localparam int unsigned ADDR_LSB  = 6;

   typedef struct packed {
      logic              twos;
      logic              stby;
      logic              swc;
      logic [ADDR_W-1:0] addr;
   } ctrl_word_t;

   function automatic ctrl_word_t unpack_ctrl(input logic [BUS_W-1:0] w);
      ctrl_word_t c;
      c.twos = w[FMT_POS];
      c.stby = w[STBY_POS];
      c.swc  = w[SWC_POS];
      c.addr = w[ADDR_LSB +: ADDR_W];
      return c;
   endfunction
endpackage

// File: rtl/adc_strobe_sync.sv
module adc_strobe_sync #(
   parameter int unsigned STAGES  = 2,
   parameter int unsigned WIDTH   = 1,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 1) begin : g_bad
         $error("adc_strobe_sync: STAGES must be at least 1");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain[i] <= RST_VAL;
            end else begin
               if (i == 0) chain[i] <= d;
               else        chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
   import adc_bus_pkg::*;
#(
   parameter int unsigned DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_cs_n,
   input  logic              s_wr_n,
   input  logic [DATA_W-1:0] s_dat,
   output logic              wr_rise,
   output ctrl_word_t        ctrl_q
);
   logic              d_cs_n;
   logic              d_wr_n;
   logic [DATA_W-1:0] d_dat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_cs_n <= 1'b1;
         d_wr_n <= 1'b1;
         d_dat  <= '0;
      end else begin
         d_cs_n <= s_cs_n;
         d_wr_n <= s_wr_n;
         d_dat  <= s_dat;
      end
   end

   // rising write strobe, qualified by select at the last low sample
   assign wr_rise = s_wr_n & ~d_wr_n & ~d_cs_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_rise) begin
         ctrl_q <= unpack_ctrl(d_dat[BUS_W-1:0]);
      end
   end
endmodule

// File: rtl/adc_settle_timer.sv
module adc_settle_timer #(
   parameter int unsigned SETTLE_CYCLES = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic sw_start,
   input  logic standby,
   output logic fire
);
   localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYCLES);

   logic [CNT_W-1:0] cnt_q;
   logic             expire;

   assign expire = (cnt_q == CNT_W'(1)) & ~load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= LOAD_VAL;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fire <= 1'b0;
      else        fire <= expire & sw_start & ~standby;
   end
endmodule

// File: rtl/adc_read_path.sv
module adc_read_path #(
   parameter int unsigned DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              twos,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_result,
   output logic [DATA_W-1:0] dout,
   output logic              oe
);
   logic [DATA_W-1:0] result_q;
   logic [DATA_W-1:0] coded;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         result_q <= '0;
      else if (conv_done) result_q <= conv_result;
   end

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_code
         if (b == DATA_W-1) begin : g_msb
            assign coded[b] = result_q[b] ^ twos;
         end else begin : g_low
            assign coded[b] = result_q[b];
         end
      end
   endgenerate

   assign oe   = ~cs_n & ~rd_n;
   assign dout = oe ? coded : '0;
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
   import adc_bus_pkg::*;
#(
   parameter int unsigned DATA_W        = 12,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned SETTLE_CYCLES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_cs_n,
   input  logic              bus_rd_n,
   input  logic              bus_wr_n,
   input  logic [DATA_W-1:0] bus_din,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_oe,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_result,
   output logic [ADDR_W-1:0] chan_sel,
   output logic              standby_req,
   output logic              hold_start
);
   generate
      if (DATA_W != BUS_W) begin : g_chk_w
         $error("adc_bus_ctrl: DATA_W must match the control field layout");
      end
      if (SYNC_STAGES < 2) begin : g_chk_s
         $error("adc_bus_ctrl: SYNC_STAGES must be at least 2");
      end
      if (SETTLE_CYCLES < 1) begin : g_chk_t
         $error("adc_bus_ctrl: SETTLE_CYCLES must be at least 1");
      end
   endgenerate

   logic [1:0]        s_strb;
   logic [DATA_W-1:0] s_dat;
   logic              wr_rise;
   ctrl_word_t        ctrl_q;

   adc_strobe_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(2'b11)) u_sync_strb (
      .clk(clk), .rst_n(rst_n), .d({bus_cs_n, bus_wr_n}), .q(s_strb)
   );

   adc_strobe_sync #(.STAGES(SYNC_STAGES), .WIDTH(DATA_W), .RST_VAL('0)) u_sync_data (
      .clk(clk), .rst_n(rst_n), .d(bus_din), .q(s_dat)
   );

   adc_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .s_cs_n(s_strb[1]), .s_wr_n(s_strb[0]),
      .s_dat(s_dat), .wr_rise(wr_rise), .ctrl_q(ctrl_q)
   );

   adc_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(wr_rise), .sw_start(ctrl_q.swc),
      .standby(ctrl_q.stby), .fire(hold_start)
   );

   adc_read_path #(.DATA_W(DATA_W)) u_read (
      .clk(clk), .rst_n(rst_n), .cs_n(bus_cs_n), .rd_n(bus_rd_n), .twos(ctrl_q.twos),
      .conv_done(conv_done), .conv_result(conv_result), .dout(bus_dout), .oe(bus_oe)
   );

   assign chan_sel    = ctrl_q.addr;
   assign standby_req = ctrl_q.stby;
endmodule

// File: rtl/adc_bus_ctrl_chk.sv
module adc_bus_ctrl_chk #(
   parameter int unsigned DATA_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_oe,
   input logic [DATA_W-1:0] bus_dout,
   input logic [2:0]        chan_sel,
   input logic              standby_req,
   input logic              hold_start,
   input logic              wr_rise,
   input logic              swc,
   input logic              twos,
   input logic [DATA_W-1:0] result_q
);
   p_float_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe |-> (bus_dout == '0));

   p_chan_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_rise |=> $stable(chan_sel));

   p_no_swc_no_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hold_start |-> swc);

   p_stby_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      standby_req |-> !hold_start);

   p_msb_coding_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && twos) |-> (bus_dout[DATA_W-1] == ~result_q[DATA_W-1]));

   p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      hold_start |=> !hold_start);
endmodule

bind adc_bus_ctrl adc_bus_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_oe(bus_oe), .bus_dout(bus_dout),
   .chan_sel(chan_sel), .standby_req(standby_req), .hold_start(hold_start),
   .wr_rise(wr_rise), .swc(ctrl_q.swc), .twos(ctrl_q.twos),
   .result_q(u_read.result_q)
);

// File: tb/sim_adc_bus_ctrl.sv
module sim_adc_bus_ctrl;
   localparam int S = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [11:0] din = '0;
   logic [11:0] dout;
   logic        oe;
   logic        cdone = 1'b0;
   logic [11:0] cres = '0;
   logic [2:0]  chan;
   logic        stby;
   logic        hstart;

   int checks = 0, fails = 0, pulses = 0;

   always #5 clk = ~clk;

   adc_bus_ctrl #(.DATA_W(12), .SYNC_STAGES(2), .SETTLE_CYCLES(S)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_rd_n(rd_n), .bus_wr_n(wr_n),
      .bus_din(din), .bus_dout(dout), .bus_oe(oe), .conv_done(cdone),
      .conv_result(cres), .chan_sel(chan), .standby_req(stby), .hold_start(hstart)
   );

   // behavioural reference model
   int hw[4], hc[4], hd[4];
   int m_twos, m_stby, m_swc, m_addr, m_res, m_cnt, m_fire;

   task automatic model_reset();
      for (int i = 0; i < 4; i++) begin hw[i] = 1; hc[i] = 1; hd[i] = 0; end
      m_twos = 0; m_stby = 0; m_swc = 0; m_addr = 0; m_res = 0; m_cnt = 0; m_fire = 0;
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) model_reset();
      else begin
         int rise, nfire;
         for (int i = 3; i > 0; i--) begin hw[i] = hw[i-1]; hc[i] = hc[i-1]; hd[i] = hd[i-1]; end
         hw[0] = wr_n; hc[0] = cs_n; hd[0] = din;
         rise  = (hw[2] == 1 && hw[3] == 0 && hc[3] == 0);
         nfire = (m_cnt == 1 && !rise && m_swc == 1 && m_stby == 0);
         if (rise) m_cnt = S; else if (m_cnt > 0) m_cnt = m_cnt - 1;
         if (rise) begin
            m_twos = (hd[3] >> 11) & 1;
            m_stby = (hd[3] >> 10) & 1;
            m_swc  = (hd[3] >> 9) & 1;
            m_addr = (hd[3] >> 6) & 7;
         end
         if (cdone) m_res = cres;
         m_fire = nfire;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // compare every cycle, away from the edge
   always @(posedge clk) begin
      #3;
      if (rst_n) begin
         int m_oe, m_out;
         m_oe  = (!cs_n && !rd_n);
         m_out = m_oe ? (m_twos ? (m_res ^ 12'h800) : m_res) : 0;
         check("R3 chan_sel", chan, m_addr);
         check("R8 standby_req", stby, m_stby);
         check("R5/R7/R11 hold_start", hstart, m_fire);
         check("R2 bus_oe", oe, m_oe);
         check("R9/R10 bus_dout", dout, m_out);
         if (hstart) pulses++;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(input logic [11:0] w, input logic sel);
      @(negedge clk); cs_n = ~sel; din = w;
      @(negedge clk); wr_n = 1'b0;
      cyc(3);         wr_n = 1'b1;
      cyc(3);         cs_n = 1'b1;
   endtask

   task automatic convert(input logic [11:0] v);
      @(negedge clk); cdone = 1'b1; cres = v;
      @(negedge clk); cdone = 1'b0;
   endtask

   task automatic bus_read(input string req, input int exp);
      @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
      #2 check(req, dout, exp);
      @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
   endtask

   function automatic logic [11:0] word(input int twos, input int sb, input int swc, input int a);
      return 12'((twos << 11) | (sb << 10) | (swc << 9) | (a << 6));
   endfunction

   bit done = 0;

   initial begin
      int p0;
      cyc(3);
      rst_n = 1'b1;
      #2;
      check("R1 chan", chan, 0);
      check("R1 standby", stby, 0);
      check("R1 hold", hstart, 0);
      check("R1 oe", oe, 0);
      cyc(2);

      convert(12'h123);
      bus_read("R9 straight", 12'h123);

      p0 = pulses;
      bus_write(word(1, 0, 0, 5), 1'b1); cyc(S + 10);
      check("R6 no start", pulses - p0, 0);
      check("R3 chan", chan, 5);
      bus_read("R10 twos", 12'h923);

      p0 = pulses;
      bus_write(word(0, 0, 1, 2), 1'b1); cyc(S + 10);
      check("R5 one start", pulses - p0, 1);

      p0 = pulses;
      bus_write(word(0, 0, 1, 7), 1'b0); cyc(S + 10);
      check("R4 chan unchanged", chan, 2);
      check("R4 no start", pulses - p0, 0);

      p0 = pulses;
      bus_write(word(0, 0, 1, 3), 1'b1); cyc(4);
      bus_write(word(0, 0, 1, 4), 1'b1); cyc(S + 10);
      check("R7 restart one start", pulses - p0, 1);
      check("R7 chan", chan, 4);

      p0 = pulses;
      bus_write(word(0, 1, 1, 6), 1'b1); cyc(S + 10);
      check("R8 standby", stby, 1);
      check("R8 no start", pulses - p0, 0);

      bus_write(word(0, 0, 0, 1) | 12'h03F, 1'b1); cyc(4);
      check("R3 low bits ignored", chan, 1);
      check("R3 standby cleared", stby, 0);

      convert(12'h800);
      bus_read("R9 msb straight", 12'h800);
      bus_write(word(1, 0, 0, 1), 1'b1); cyc(4);
      bus_read("R10 msb twos", 12'h000);

      @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
      #2 check("R2 no select", oe, 0);
      check("R2 floats zero", dout, 0);
      @(negedge clk); rd_n = 1'b1;
      cyc(3);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            #1_000_000;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule